// File: doc/BRIEF.md
# Autonomous Converter Readout Master

This block sits next to a successive-approximation ADC and fetches its results without any host involvement. A rising edge on the conversion-start input is forwarded to the converter after one clock. The block then waits for the converter's busy line to fall. When it does, the block drives a serial clock and shifts in a programmable number of bits from two serial data lines at once. Each completed pair of words is presented on parallel outputs, together with a one-cycle valid strobe and the index of the word within the read.

Clock rate, word length and the number of chained words per line are set by small code inputs. These codes are captured when a read begins. A converter that has no busy output is supported by tying its busy pin to the forwarded conversion-start output. A start edge that arrives while a read is still in progress is dropped, and a sticky flag records it.

Top module: `adc_fetch_master`

## Requirements
- R1: While rst_ni is low, and up to the first start edge after it, cnv_o, sck_o, word_vld_o and overrun_o are 0.
- R2: When idle, a rising edge on cnv_i sets cnv_o high one clock later. cnv_o then stays high until one clock after cnv_i falls.
- R3: After a start has been accepted, the first high-to-low transition of busy_i begins the read. sck_o first rises H clocks after the edge at which that transition is seen, where H is the half period.
- R4: sck_o idles low. During a read, each high phase and each low phase of sck_o lasts H clocks. H is set by clk_sel_i codes 0..7 as 1, 2, 3, 4, 6, 8, 12 and 16.
- R5: len_sel_i codes 0..7 select word lengths of 32, 28, 24, 20, 18, 16, 12 and 8 bits. Data is taken MSB first at the clock edge where sck_o goes low. Each word is right-aligned, with zeros above its length.
- R6: sdi_a_i and sdi_b_i are sampled on the same edges. They yield word_a_o and word_b_o together.
- R7: cnt_sel_i codes 0..3 select 1..4 words per line, which is 2, 4, 6 or 8 chained devices. word_idx_o counts the words of a read from 0.
- R8: With busy_i tied to cnv_o, a read still starts once busy falls, and it completes.
- R9: A rising edge on cnv_i during a read is not forwarded to cnv_o and does not restart the read. It sets overrun_o, which stays set until reset.
- R10: word_vld_o is a one-clock pulse in the cycle after the sck_o falling edge that takes the last bit of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_i | input | 1 | Conversion-start request |
| busy_i | input | 1 | Converter busy line |
| sdi_a_i | input | 1 | Serial data line A |
| sdi_b_i | input | 1 | Serial data line B |
| clk_sel_i | input | 3 | Serial clock rate code |
| len_sel_i | input | 3 | Word length code |
| cnt_sel_i | input | 2 | Words per line minus one |
| cnv_o | output | 1 | Forwarded conversion start |
| sck_o | output | 1 | Serial clock |
| word_a_o | output | 32 | Captured word from line A |
| word_b_o | output | 32 | Captured word from line B |
| word_idx_o | output | 2 | Index of the presented word |
| word_vld_o | output | 1 | Word strobe |
| overrun_o | output | 1 | Sticky dropped-start flag |

## Verification
A wrong divider or phase state shows up on sck_o within one half period, because the bench compares the serial clock on every cycle. A wrong bit counter or word counter moves the valid strobe, so word_vld_o appears in the wrong cycle on the first word of the read. A shift or lane error corrupts the word value in that same cycle. A fault in the sequencing or edge-detect state appears as a missing, extra or early cnv_o edge, or as a wrong overrun_o, within one clock of the triggering input.

// File: rtl/adc_fetch_pkg.sv
package adc_fetch_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_SHIFT} fetch_st_e;

  function automatic logic [4:0] half_of(input logic [2:0] code);
    case (code)
      3'd0: half_of = 5'd1;
      3'd1: half_of = 5'd2;
      3'd2: half_of = 5'd3;
      3'd3: half_of = 5'd4;
      3'd4: half_of = 5'd6;
      3'd5: half_of = 5'd8;
      3'd6: half_of = 5'd12;
      default: half_of = 5'd16;
    endcase
  endfunction

  function automatic logic [5:0] len_of(input logic [2:0] code);
    case (code)
      3'd0: len_of = 6'd32;
      3'd1: len_of = 6'd28;
      3'd2: len_of = 6'd24;
      3'd3: len_of = 6'd20;
      3'd4: len_of = 6'd18;
      3'd5: len_of = 6'd16;
      3'd6: len_of = 6'd12;
      default: len_of = 6'd8;
    endcase
  endfunction
endpackage

// File: rtl/afm_sck_gen.sv
module afm_sck_gen #(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sck_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] div_q;
  logic             sck_q;
  logic             tick;

  assign tick   = (div_q == half_i - 1'b1);
  assign sck_o  = sck_q;
  assign fall_o = run_i & tick & sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R4
  sck_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sck_o);
endmodule

// File: rtl/afm_lane.sv
module afm_lane #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         shift_i,
  input  logic         sdi_i,
  output logic [W-1:0] nxt_o
);
  logic [W-2:0] sr_q;

  assign nxt_o = {sr_q, sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (clear_i) sr_q <= '0;
    else if (shift_i) sr_q <= nxt_o[W-2:0];
  end
endmodule

// File: rtl/adc_fetch_master.sv
module adc_fetch_master
  import adc_fetch_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 2,
  parameter int DIV_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_i,
  input  logic              busy_i,
  input  logic              sdi_a_i,
  input  logic              sdi_b_i,
  input  logic [2:0]        clk_sel_i,
  input  logic [2:0]        len_sel_i,
  input  logic [CNT_W-1:0]  cnt_sel_i,
  output logic              cnv_o,
  output logic              sck_o,
  output logic [WORD_W-1:0] word_a_o,
  output logic [WORD_W-1:0] word_b_o,
  output logic [CNT_W-1:0]  word_idx_o,
  output logic              word_vld_o,
  output logic              overrun_o
);
  localparam int LANES = 2;
  localparam int BIT_W = $clog2(WORD_W + 1);

  fetch_st_e         state_q;
  logic              cnv_d_q, busy_d_q, cnv_q, ovr_q, vld_q;
  logic [DIV_W-1:0]  half_q;
  logic [BIT_W-1:0]  len_q, bit_q;
  logic [CNT_W-1:0]  cnt_q, widx_q, idx_q;
  logic [WORD_W-1:0] a_q, b_q;

  logic start, rise, fall, word_done, last_word, run;
  logic [LANES-1:0]  sdi_w;
  logic [WORD_W-1:0] nxt_w [LANES];

  assign rise      = cnv_i & ~cnv_d_q;
  assign start     = (state_q == ST_ARMED) & busy_d_q & ~busy_i;
  assign run       = (state_q == ST_SHIFT);
  assign word_done = fall & (bit_q == len_q - 1'b1);
  assign last_word = (widx_q == cnt_q);
  assign sdi_w     = {sdi_b_i, sdi_a_i};

  afm_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run),
    .half_i(half_q), .sck_o(sck_o), .fall_o(fall)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    afm_lane #(.W(WORD_W)) u_lane (
      .clk_i  (clk_i), .rst_ni(rst_ni),
      .clear_i(start | word_done), .shift_i(fall),
      .sdi_i  (sdi_w[g]), .nxt_o(nxt_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnv_d_q  <= 1'b0;
      busy_d_q <= 1'b0;
      cnv_q    <= 1'b0;
      ovr_q    <= 1'b0;
      vld_q    <= 1'b0;
      half_q   <= DIV_W'(1);
      len_q    <= BIT_W'(WORD_W);
      cnt_q    <= '0;
      bit_q    <= '0;
      widx_q   <= '0;
      idx_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
    end else begin
      cnv_d_q  <= cnv_i;
      busy_d_q <= busy_i;
      vld_q    <= 1'b0;
      // forward only edges accepted while idle
      cnv_q    <= cnv_i & (cnv_q | (state_q == ST_IDLE));
      if (rise && state_q != ST_IDLE) ovr_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (rise) state_q <= ST_ARMED;
        ST_ARMED: if (start) begin
          state_q <= ST_SHIFT;
          half_q  <= DIV_W'(half_of(clk_sel_i));
          len_q   <= BIT_W'(len_of(len_sel_i));
          cnt_q   <= cnt_sel_i;
          bit_q   <= '0;
          widx_q  <= '0;
        end
        ST_SHIFT: if (fall) begin
          if (word_done) begin
            bit_q <= '0;
            vld_q <= 1'b1;
            idx_q <= widx_q;
            a_q   <= nxt_w[0];
            b_q   <= nxt_w[1];
            if (last_word) state_q <= ST_IDLE;
            else           widx_q  <= widx_q + 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o      = cnv_q;
  assign overrun_o  = ovr_q;
  assign word_vld_o = vld_q;
  assign word_idx_o = idx_q;
  assign word_a_o   = a_q;
  assign word_b_o   = b_q;

  // R2
  cnv_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> $past(cnv_i));
  // R9
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  // R10
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);
  // R5
  word_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> ((word_a_o >> len_q) == '0) && ((word_b_o >> len_q) == '0));
endmodule

// File: tb/sim_adc_fetch_master.sv
`timescale 1ns/1ps
module sim_adc_fetch_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0, busy_drv = 1'b0, tie = 1'b0;
  logic sdi_a = 1'b0, sdi_b = 1'b0;
  logic [2:0] clk_sel = '0, len_sel = '0;
  logic [1:0] cnt_sel = '0;
  logic busy, cnv_o, sck_o, vld_o, ovr_o;
  logic [31:0] wa_o, wb_o;
  logic [1:0] idx_o;

  always #2.5 clk = ~clk;
  assign busy = tie ? cnv_o : busy_drv;

  adc_fetch_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnv_i(cnv), .busy_i(busy),
    .sdi_a_i(sdi_a), .sdi_b_i(sdi_b), .clk_sel_i(clk_sel),
    .len_sel_i(len_sel), .cnt_sel_i(cnt_sel), .cnv_o(cnv_o),
    .sck_o(sck_o), .word_a_o(wa_o), .word_b_o(wb_o),
    .word_idx_o(idx_o), .word_vld_o(vld_o), .overrun_o(ovr_o)
  );

  int compared = 0, mismatched = 0, cycles = 0;
  int half_tab[8] = '{1, 2, 3, 4, 6, 8, 12, 16};
  int len_tab[8]  = '{32, 28, 24, 20, 18, 16, 12, 8};
  logic [31:0] pat_a[4], pat_b[4];
  int cur_len = 32, nbits = 0, vld_seen = 0;
  logic sck_prev = 1'b0;

  // reference model state
  int m_phase, m_tick, m_half, m_len, m_cnt, m_bits, m_word;
  logic m_cnv_d, m_busy_d, e_cnv, e_sck, e_vld, e_ovr;
  int e_idx;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input int len);
    return (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_tick = 0; m_bits = 0; m_word = 0;
      m_half = 1; m_len = 32; m_cnt = 1;
      m_cnv_d = 0; m_busy_d = 0;
      e_cnv = 0; e_sck = 0; e_vld = 0; e_ovr = 0; e_idx = 0;
    end else begin
      automatic logic r = cnv && !m_cnv_d;
      e_vld = 0;
      if (r && m_phase != 0) e_ovr = 1;
      e_cnv = cnv && (e_cnv || m_phase == 0);
      case (m_phase)
        0: if (r) m_phase = 1;
        1: if (m_busy_d && !busy) begin
          m_phase = 2; m_tick = 0; e_sck = 0; m_bits = 0; m_word = 0;
          m_half = half_tab[clk_sel]; m_len = len_tab[len_sel]; m_cnt = cnt_sel + 1;
        end
        default: begin
          if (m_tick == m_half - 1) begin
            m_tick = 0;
            if (e_sck) begin
              e_sck = 0;
              m_bits++;
              if (m_bits == m_len) begin
                m_bits = 0; e_vld = 1; e_idx = m_word; m_word++;
                if (m_word == m_cnt) m_phase = 0;
              end
            end else e_sck = 1;
          end else m_tick++;
        end
      endcase
      m_cnv_d = cnv;
      m_busy_d = busy;
    end
  end

  // converter data source and per-cycle comparison
  always @(negedge clk) begin
    cycles++;
    if (sck_o && !sck_prev) begin
      automatic int w = nbits / cur_len;
      automatic int p = cur_len - 1 - (nbits % cur_len);
      if (w < 4) begin
        sdi_a = pat_a[w][p];
        sdi_b = pat_b[w][p];
      end
      nbits++;
    end
    sck_prev = sck_o;
    if (rst_n) begin
      chk(sck_o === e_sck, "R4 sck_o", sck_o, e_sck);
      chk(cnv_o === e_cnv, "R2 cnv_o", cnv_o, e_cnv);
      chk(vld_o === e_vld, "R10 word_vld_o", vld_o, e_vld);
      chk(ovr_o === e_ovr, "R9 overrun_o", ovr_o, e_ovr);
      if (e_vld) begin
        vld_seen++;
        chk(wa_o === (pat_a[e_idx] & msk(m_len)), "R5 word_a_o", wa_o, pat_a[e_idx] & msk(m_len));
        chk(wb_o === (pat_b[e_idx] & msk(m_len)), "R6 word_b_o", wb_o, pat_b[e_idx] & msk(m_len));
        chk(idx_o === 2'(e_idx), "R7 word_idx_o", idx_o, e_idx);
      end
    end
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (m_phase == 0 && !e_vld) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input int c, input int l, input int n, input logic [31:0] seed);
    clk_sel = 3'(c); len_sel = 3'(l); cnt_sel = 2'(n);
    cur_len = len_tab[l];
    for (int i = 0; i < 4; i++) begin
      pat_a[i] = seed ^ (32'h9E37_79B9 * (i + 1));
      pat_b[i] = ~seed + (32'h0F1E_2D3C << i);
    end
    nbits = 0; vld_seen = 0;
  endtask

  task automatic read(input int c, input int l, input int n, input logic [31:0] seed,
                      input logic tied, input logic dbl);
    setup(c, l, n, seed);
    tie = tied;
    @(negedge clk);
    cnv = 1'b1; busy_drv = 1'b1;
    repeat (3) @(negedge clk);
    cnv = 1'b0;
    repeat (5) @(negedge clk);
    busy_drv = 1'b0;
    if (dbl) begin
      repeat (20) @(negedge clk);
      cnv = 1'b1;
      repeat (2) @(negedge clk);
      cnv = 1'b0;
    end
    wait_idle();
    if (tied) chk(vld_seen == n + 1, "R8 tied read words", vld_seen, n + 1);
    else      chk(vld_seen == n + 1, "R3 R7 auto read words", vld_seen, n + 1);
    tie = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({cnv_o, sck_o, vld_o, ovr_o} === 4'b0, "R1 reset outputs", {cnv_o, sck_o, vld_o, ovr_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({cnv_o, sck_o, vld_o, ovr_o} === 4'b0, "R1 after reset", {cnv_o, sck_o, vld_o, ovr_o}, 0);
    read(0, 2, 0, 32'hA5C3_0F81, 1'b0, 1'b0);
    read(7, 7, 3, 32'h1234_5678, 1'b0, 1'b0);
    read(4, 0, 1, 32'hFFFF_0001, 1'b0, 1'b0);
    read(2, 4, 2, 32'h8000_7FFE, 1'b0, 1'b0);
    read(1, 6, 0, 32'h0000_0000, 1'b0, 1'b0);
    read(3, 1, 1, 32'hDEAD_BEEF, 1'b1, 1'b0);
    read(5, 5, 3, 32'h5A5A_A5A5, 1'b1, 1'b0);
    read(6, 3, 1, 32'h0BAD_F00D, 1'b0, 1'b1);
    chk(ovr_o === 1'b1, "R9 overrun set", ovr_o, 1);
    read(0, 7, 0, 32'h7777_1111, 1'b0, 1'b0);
    chk(ovr_o === 1'b1, "R9 overrun held", ovr_o, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule